// File: doc/BRIEF.md
# Byte-Wide EEPROM Write Sequencer with Completion Polling

This block sits on the host side of a parallel EEPROM that uses static-RAM style strobes: active-low chip enable, output enable and write enable, an address bus and a bidirectional byte bus. A client hands it one address and one data byte through a valid/ready handshake. The block then runs a complete byte program cycle. It drives the enables in a safe order, holds the address through the whole write, and keeps the data steady until write enable rises. It then finds out when the device's internal program cycle has finished.

The block does not wait for a fixed worst-case time. It keeps reading the location it just wrote. While the device is busy, bit 7 of every read comes back inverted. Once bit 7 matches the written value, one more full-byte read confirms the whole byte. The outcome goes back to the client as a single-cycle pulse: success, timeout, or verify mismatch. A supply-good input opens the request port only after a programmable settling delay.

States: `ST_IDLE` waits for a request. `ST_SETUP` drives the enables, address and data. `ST_STROBE` holds write enable low. `ST_HOLD` keeps the data after write enable rises. `ST_TURN` is one cycle with the bus released. `ST_POLL` is a status read. `ST_GAP` is one cycle between reads. `ST_VERIFY` is the final read. The transitions are as follows:
- Accept: idle to setup.
- After each phase's count: setup to strobe, strobe to hold, hold to turn, and turn to poll.
- Poll miss: poll to gap, and then gap back to poll.
- Poll hit: poll to verify.
- Expiry: any polling state to idle.
- Verify end: verify to idle.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: `req_ready` stays low, and chip enable never falls, until `supply_ok` has been high for PWRUP_CYC consecutive clock edges. Any cycle with `supply_ok` low drops `req_ready` on the next edge and restarts the count.
- R2: After a request is accepted, the strobes follow a fixed pattern, counted in clock cycles. First comes SETUP_CYC cycles with chip enable low, output enable high, write enable high and the byte driven. Next comes PULSE_CYC cycles with write enable low. Last comes HOLD_CYC cycles with write enable high and the byte still driven.
- R3: While chip enable is low, `mem_addr` holds the accepted address. `mem_dq_o` does not change while `mem_dq_oe` is high, and `mem_dq_oe` is high at the cycle where write enable rises.
- R4: After the hold, there is one turnaround cycle with `mem_dq_oe` low and output enable high. Then come status reads of READ_CYC cycles each, with chip enable and output enable low and write enable high. Each read is sampled in its last cycle. If `mem_dq_i[7]` differs from bit 7 of the written byte, output enable goes high for one cycle and a new read starts.
- R5: A matching bit 7 starts a verify read of READ_CYC cycles with output enable kept low. If all 8 bits equal the written byte, `done_o` pulses for one cycle and the block returns to idle.
- R6: `mem_dq_oe` is never high in a cycle where output enable is low.
- R7: If the verify read differs from the written byte in any bit, `fail_verify_o` pulses for one cycle instead of `done_o`.
- R8: The polling window starts with the turnaround cycle. If no read has matched by the TIMEOUT_CYC-th cycle of the window, `fail_timeout_o` pulses, all enables go high, and the block idles. A read whose matching sample falls in exactly that cycle counts as a completion.
- R9: Each accepted request produces exactly one outcome pulse. `req_ready` is low from the cycle after acceptance until the outcome cycle, and it is high in the outcome cycle.
- R10: In reset and in idle, chip enable, output enable and write enable are high and `mem_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Device supply is within range |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request port open |
| req_addr | input | AW | Byte address to program |
| req_data | input | 8 | Byte to program |
| done_o | output | 1 | One-cycle pulse: byte written and confirmed |
| fail_timeout_o | output | 1 | One-cycle pulse: polling window expired |
| fail_verify_o | output | 1 | One-cycle pulse: verify read mismatched |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_addr | output | AW | Device address bus |
| mem_dq_o | output | 8 | Byte driven toward the device |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Byte read from the device |

## Verification
Two events can fall in the same cycle: the polling timeout expiring, and a status read seeing a matching bit 7. The bench sets the window to exactly eight read periods. Its device model turns ready on a chosen read count, so the eighth read's sample lands on the expiry cycle. With the device ready on read eight, the bench expects a success pulse after the verify read, at a computed latency. With the device ready on read nine, it expects a timeout pulse at the window's end. Either way, exactly one outcome pulse must appear.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN,
        ST_POLL,
        ST_GAP,
        ST_VERIFY
    } eep_state_e;

endpackage

// File: rtl/eep_pwr_gate.sv
module eep_pwr_gate #(
    parameter int DELAY_CYC = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic pwr_ok
);

    localparam int CW = $clog2(DELAY_CYC + 1);

    logic [CW-1:0] settle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt <= '0;
        end else if (!supply_ok) begin
            settle_cnt <= '0;
        end else if (settle_cnt != CW'(DELAY_CYC)) begin
            settle_cnt <= settle_cnt + 1'b1;
        end
    end

    assign pwr_ok = (settle_cnt == CW'(DELAY_CYC));

    p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !pwr_ok);

endmodule

// File: rtl/eep_wait_timer.sv
module eep_wait_timer #(
    parameter int LIMIT_CYC = 26000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT_CYC + 1);

    logic [TW-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (!run) begin
            win_cnt <= '0;
        end else if (win_cnt != TW'(LIMIT_CYC - 1)) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    assign expired = run && (win_cnt == TW'(LIMIT_CYC - 1));

    p_expiry_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && $past(run)) |-> $past(win_cnt) == TW'(LIMIT_CYC - 2) || $past(expired));

endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
    import eep_pkg::*;
#(
    parameter int AW          = 11,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 4,
    parameter int HOLD_CYC    = 2,
    parameter int READ_CYC    = 2,
    parameter int PWRUP_CYC   = 625000,
    parameter int TIMEOUT_CYC = 26000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done_o,
    output logic          fail_timeout_o,
    output logic          fail_verify_o,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [7:0]    mem_dq_i
);

    localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_B = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int MAXPH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PHW   = $clog2(MAXPH + 1);

    eep_state_e    state, state_nx;
    logic [PHW-1:0] ph_cnt, ph_end;
    logic          ph_last;
    logic          pwr_ok;
    logic          accept;
    logic          win_run, win_exp;
    logic          poll_hit, vfy_end, vfy_ok;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          done_q, tout_q, vfail_q;

    eep_pwr_gate #(.DELAY_CYC(PWRUP_CYC)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pwr_ok    (pwr_ok)
    );

    eep_wait_timer #(.LIMIT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (win_run),
        .expired (win_exp)
    );

    assign req_ready = (state == ST_IDLE) && pwr_ok;
    assign accept    = req_valid && req_ready;

    // Length of the current timed phase, minus one
    always_comb begin
        unique case (state)
            ST_SETUP:            ph_end = PHW'(SETUP_CYC - 1);
            ST_STROBE:           ph_end = PHW'(PULSE_CYC - 1);
            ST_HOLD:             ph_end = PHW'(HOLD_CYC - 1);
            ST_POLL, ST_VERIFY:  ph_end = PHW'(READ_CYC - 1);
            default:             ph_end = '0;
        endcase
    end

    assign ph_last  = (ph_cnt == ph_end);
    assign win_run  = (state == ST_TURN) || (state == ST_POLL) || (state == ST_GAP);
    assign poll_hit = (state == ST_POLL) && ph_last && (mem_dq_i[7] == data_q[7]);
    assign vfy_end  = (state == ST_VERIFY) && ph_last;
    assign vfy_ok   = (mem_dq_i == data_q);

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept)  state_nx = ST_SETUP;
            ST_SETUP:  if (ph_last) state_nx = ST_STROBE;
            ST_STROBE: if (ph_last) state_nx = ST_HOLD;
            ST_HOLD:   if (ph_last) state_nx = ST_TURN;
            ST_TURN,
            ST_POLL,
            ST_GAP: begin
                if (poll_hit)                            state_nx = ST_VERIFY;
                else if (win_exp)                        state_nx = ST_IDLE;
                else if (state == ST_TURN)               state_nx = ST_POLL;
                else if (state == ST_GAP)                state_nx = ST_POLL;
                else if (ph_last)                        state_nx = ST_GAP;
            end
            ST_VERIFY: if (ph_last) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state || state == ST_IDLE) begin
                ph_cnt <= '0;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    // Request capture and outcome pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            tout_q  <= 1'b0;
            vfail_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
            done_q  <= vfy_end && vfy_ok;
            vfail_q <= vfy_end && !vfy_ok;
            tout_q  <= win_run && win_exp && !poll_hit;
        end
    end

    // Strobe outputs decoded from the state
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SETUP, ST_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_STROBE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_TURN, ST_GAP: mem_ce_n = 1'b0;
            ST_POLL, ST_VERIFY: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign mem_addr       = addr_q;
    assign mem_dq_o       = data_q;
    assign done_o         = done_q;
    assign fail_timeout_o = tout_q;
    assign fail_verify_o  = vfail_q;

    p_strobe_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_data_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

    p_bus_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_holdoff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $past(pwr_ok));

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_timeout_o, fail_verify_o}));

    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_timeout_o |-> (mem_ce_n && mem_oe_n && mem_we_n));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/sim_eeprom_prog_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_prog_ctrl;

    localparam int AW   = 11;
    localparam int S_C  = 2;
    localparam int P_C  = 3;
    localparam int H_C  = 2;
    localparam int R_C  = 2;
    localparam int PW_C = 20;
    localparam int TO_C = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          done_o, fail_timeout_o, fail_verify_o;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eeprom_prog_ctrl #(
        .AW(AW), .SETUP_CYC(S_C), .PULSE_CYC(P_C), .HOLD_CYC(H_C),
        .READ_CYC(R_C), .PWRUP_CYC(PW_C), .TIMEOUT_CYC(TO_C)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .done_o(done_o), .fail_timeout_o(fail_timeout_o), .fail_verify_o(fail_verify_o),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // Device model: busy until the k_ready-th read after the write
    logic [7:0] mem_q [0:(1<<AW)-1];
    int         k_ready = 1;
    bit         corrupt = 1'b0;
    int         rd_cnt = 0;
    logic [AW-1:0] exp_addr = '0;

    assign mem_dq_i = (!mem_ce_n && !mem_oe_n)
                    ? ((rd_cnt < k_ready) ? ~mem_q[mem_addr]
                                          : (mem_q[mem_addr] ^ {7'b0, corrupt}))
                    : 8'h00;

    // Bus monitor: rule violations and segment log of {ce,oe,we,dq_oe}
    logic [3:0] seg_code [0:15];
    int         seg_len  [0:15];
    int         seg_n = 0;
    logic [3:0] cur_code = 4'b1110;
    logic [3:0] mon_code;
    int         cur_len = 0;
    int         viol = 0;
    int         ce_falls = 0;
    logic       prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_dqoe = 1'b0;
    logic [7:0] prev_dq = '0;

    always @(negedge clk) begin
        mon_code = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
        if (mon_code == cur_code) begin
            cur_len++;
        end else begin
            if (cur_code == 4'b1110) seg_n = 0;
            else if (seg_n < 16) begin
                seg_code[seg_n] = cur_code;
                seg_len[seg_n]  = cur_len;
                seg_n++;
            end
            cur_code = mon_code;
            cur_len  = 1;
        end
        if (!mem_we_n && (mem_ce_n || !mem_oe_n)) viol++;
        if (!mem_oe_n && mem_dq_oe) viol++;
        if (!mem_ce_n && mem_addr != exp_addr) viol++;
        if (mem_dq_oe && prev_dqoe && mem_dq_o != prev_dq) viol++;
        if (prev_ce && !mem_ce_n) ce_falls++;
        if (!prev_we && mem_we_n) begin
            if (!mem_dq_oe) viol++;
            mem_q[mem_addr] = mem_dq_o;
            rd_cnt = 0;
        end
        if (prev_oe && !mem_oe_n) rd_cnt++;
        prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n;
        prev_dqoe = mem_dq_oe; prev_dq = mem_dq_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one request; outcome 1 done, 2 timeout, 3 verify fail, 0 none
    task automatic run_write(input logic [AW-1:0] a, input logic [7:0] d,
                             input int k, input bit cor,
                             output int outcome, output int lat, output int rdy_bad);
        @(negedge clk);
        k_ready = k; corrupt = cor; exp_addr = a;
        req_addr = a; req_data = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; rdy_bad = 0;
        while (!(done_o || fail_timeout_o || fail_verify_o) && lat < 400) begin
            if (req_ready) rdy_bad++;
            @(negedge clk);
            lat++;
        end
        outcome = done_o ? 1 : fail_timeout_o ? 2 : fail_verify_o ? 3 : 0;
        if (!req_ready) rdy_bad++;
        @(negedge clk);
        if (done_o || fail_timeout_o || fail_verify_o) rdy_bad++;
    endtask

    task automatic t_reset;
        #1;
        chk("R10 ce idle", mem_ce_n, 1);
        chk("R10 oe idle", mem_oe_n, 1);
        chk("R10 we idle", mem_we_n, 1);
        chk("R10 bus released", mem_dq_oe, 0);
        chk("R1 not ready in reset", req_ready, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_powerup;
        @(negedge clk);
        supply_ok = 1'b1; req_valid = 1'b1;
        repeat (10) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R1 supply drop", req_ready, 0);
        supply_ok = 1'b1;
        repeat (PW_C - 1) @(negedge clk);
        chk("R1 held off", req_ready, 0);
        chk("R1 no strobe while held", ce_falls, 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 opens after delay", req_ready, 1);
    endtask

    task automatic t_basic;
        int oc, lat, rb;
        viol = 0;
        run_write(11'h123, 8'h5A, 1, 1'b0, oc, lat, rb);
        chk("R5 done outcome", oc, 1);
        chk("R5 latency", lat, S_C + P_C + H_C + 1 * (R_C + 1) + R_C + 1);
        chk("R5 stored byte", mem_q[11'h123], 8'h5A);
        chk("R9 ready and single pulse", rb, 0);
        chk("R2 setup seg", {28'h0, seg_code[0]}, 4'b0111);
        chk("R2 setup len", seg_len[0], S_C);
        chk("R2 pulse seg", {28'h0, seg_code[1]}, 4'b0101);
        chk("R2 pulse len", seg_len[1], P_C);
        chk("R2 hold len", seg_len[2], H_C);
        chk("R4 turn seg", {28'h0, seg_code[3]}, 4'b0110);
        chk("R4 turn len", seg_len[3], 1);
        chk("R4 read seg", {28'h0, seg_code[4]}, 4'b0010);
        chk("R3 R6 bus rules", viol, 0);
    endtask

    task automatic t_patterns;
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h80, 8'h7F};
        int oc, lat, rb;
        for (int i = 0; i < 4; i++) begin
            viol = 0;
            run_write(AW'(i * 511 + 3), pats[i], 3, 1'b0, oc, lat, rb);
            chk("R4 R5 pattern done", oc, 1);
            chk("R4 pattern latency", lat, S_C + P_C + H_C + 3 * (R_C + 1) + R_C + 1);
            chk("R4 first read len", seg_len[4], R_C);
            chk("R4 gap seg", {28'h0, seg_code[5]}, 4'b0110);
            chk("R5 pattern stored", mem_q[AW'(i * 511 + 3)], pats[i]);
            chk("R3 R6 pattern bus", viol, 0);
        end
    endtask

    task automatic t_verify_fail;
        int oc, lat, rb;
        run_write(11'h040, 8'hC3, 2, 1'b1, oc, lat, rb);
        chk("R7 verify mismatch", oc, 3);
        chk("R9 verify single pulse", rb, 0);
    endtask

    task automatic t_timeout;
        int oc, lat, rb;
        run_write(11'h2AA, 8'h11, 50, 1'b0, oc, lat, rb);
        chk("R8 timeout outcome", oc, 2);
        chk("R8 timeout latency", lat, S_C + P_C + H_C + TO_C + 1);
        chk("R8 enables released", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk("R9 timeout single pulse", rb, 0);
    endtask

    task automatic t_boundary;
        int oc, lat, rb;
        run_write(11'h555, 8'h96, 8, 1'b0, oc, lat, rb);
        chk("R8 hit on expiry cycle wins", oc, 1);
        chk("R8 hit latency", lat, S_C + P_C + H_C + 8 * (R_C + 1) + R_C + 1);
        run_write(11'h556, 8'h69, 9, 1'b0, oc, lat, rb);
        chk("R8 one read late", oc, 2);
        chk("R8 late latency", lat, S_C + P_C + H_C + TO_C + 1);
        run_write(11'h557, 8'h24, 1, 1'b0, oc, lat, rb);
        chk("R5 recovers after timeout", oc, 1);
    endtask

    task automatic t_supply_loss;
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R1 ready drops on supply loss", req_ready, 0);
        supply_ok = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_q[i] = 8'hFF;
        t_reset();
        t_powerup();
        t_basic();
        t_patterns();
        t_verify_fail();
        t_timeout();
        t_boundary();
        t_supply_loss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule